// File: doc/BRIEF.md
# Predicated Commit and Zero Flag Unit

This unit sits between the decoder and the state-changing parts of a small 16-bit register machine. Every instruction carries a two-bit condition suffix. The suffix either executes the instruction always, executes it always and records whether its result was zero, or executes it only when the Zero flag is set or only when it is clear. For each valid instruction the unit decides whether it commits. It then turns that decision into exactly one gated side-effect strobe, chosen by the instruction class: a general register write, a program-counter write, a memory store, a constant-prefix load or a halt request.

The machine has no branch instructions. A jump is an ordinary write whose destination is register 15. For that reason, a write to register 15 is steered onto its own strobe, `pc_we`, and is gated like any other write. When that write is suppressed, `pc_we` stays low and the fetch logic keeps counting sequentially. The only architectural state held here is the Zero flag. The strobe outputs are combinational in the current instruction's inputs, and the flag is registered.

Top module: `pred_exec_unit`

## Requirements
- R1: After reset `zero_flag` is 0. While `op_valid` is 0, every output strobe (`commit`, `reg_we`, `pc_we`, `mem_we`, `pre_we`, `halt`) is 0 and `zero_flag` holds its value.
- R2: With `cond_sel` = 2'b00 (always), a valid instruction commits and `zero_flag` keeps its value.
- R3: With `cond_sel` = 2'b01 (always and set), a valid instruction of any class other than prefix commits. On the next clock edge `zero_flag` becomes 1 if `result` is zero and 0 otherwise.
- R4: With `cond_sel` = 2'b10 (if equal), a valid instruction commits exactly when `zero_flag` is 1, and `zero_flag` keeps its value.
- R5: With `cond_sel` = 2'b11 (if not equal), a valid instruction commits exactly when `zero_flag` is 0, and `zero_flag` keeps its value.
- R6: A prefix instruction (`op_kind` = 2'b10) never changes `zero_flag`, even with `cond_sel` = 2'b01. When it commits it raises `pre_we`.
- R7: A system-call instruction (`op_kind` = 2'b11) raises `halt` when it commits. When its condition fails, `halt` stays 0.
- R8: A committed register write (`op_kind` = 2'b00) to `dest_idx` = 15 raises `pc_we` and not `reg_we`. A committed write to any other index raises `reg_we` and not `pc_we`. A suppressed write raises neither.
- R9: A committed store (`op_kind` = 2'b01) raises `mem_we`. At most one of `reg_we`, `pc_we`, `mem_we`, `pre_we` and `halt` is 1 in any cycle, and none is 1 unless `commit` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Result-valid strobe for the current instruction |
| cond_sel | input | 2 | Condition suffix: 00 always, 01 always+set, 10 if Zero, 11 if not Zero |
| op_kind | input | 2 | Instruction class: 00 register write, 01 store, 10 prefix, 11 system call |
| dest_idx | input | 4 | Destination register index of a register write |
| result | input | 16 | Result value that is tested for zero |
| commit | output | 1 | The instruction executes |
| reg_we | output | 1 | Gated write to a general register (not r15) |
| pc_we | output | 1 | Gated write to r15, the program counter (taken branch) |
| mem_we | output | 1 | Gated memory store |
| pre_we | output | 1 | Gated constant-prefix load |
| halt | output | 1 | Gated halt request from a system call |
| zero_flag | output | 1 | Current Zero condition flag |

## Verification
A wrong Zero flag value does not show at the flag port when an always or set instruction executes. It shows on the next conditional instruction, where `commit` and its class strobe take the opposite value, for example a branch taken through `pc_we` that should have fallen through. The vector walk therefore places conditional instructions directly after each flag update. A flag that was updated on the wrong edge, or updated by a prefix, is then caught within one instruction both at `zero_flag` and at the gated strobes.

// File: rtl/pred_pkg.sv
package pred_pkg;
    typedef enum logic [1:0] {
        SFX_ALWAYS = 2'b00,
        SFX_SET    = 2'b01,
        SFX_IFZ    = 2'b10,
        SFX_IFNZ   = 2'b11
    } sfx_e;

    typedef enum logic [1:0] {
        KIND_REGWR  = 2'b00,
        KIND_STORE  = 2'b01,
        KIND_PREFIX = 2'b10,
        KIND_SYSCALL = 2'b11
    } kind_e;

    typedef struct packed {
        logic reg_we;
        logic pc_we;
        logic mem_we;
        logic pre_we;
        logic halt;
    } effect_t;

    typedef struct packed {
        logic zero;
    } flag_state_t;
endpackage

// File: rtl/pred_cond_eval.sv
module pred_cond_eval
    import pred_pkg::*;
(
    input  logic       valid_i,
    input  logic [1:0] sfx_i,
    input  logic       zero_i,
    output logic       commit_o,
    output logic       set_req_o
);
    always_comb begin
        commit_o  = 1'b0;
        set_req_o = 1'b0;
        if (valid_i) begin
            unique case (sfx_e'(sfx_i))
                SFX_ALWAYS: commit_o = 1'b1;
                SFX_SET: begin
                    commit_o  = 1'b1;
                    set_req_o = 1'b1;
                end
                SFX_IFZ:  commit_o = zero_i;
                SFX_IFNZ: commit_o = ~zero_i;
                default:  commit_o = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/pred_effect_gate.sv
module pred_effect_gate
    import pred_pkg::*;
#(
    parameter int REG_IDX_W = 4
) (
    input  logic                 commit_i,
    input  logic [1:0]           kind_i,
    input  logic [REG_IDX_W-1:0] dest_i,
    output effect_t              fx_o,
    output logic                 flag_ok_o
);
    localparam logic [REG_IDX_W-1:0] PC_IDX = {REG_IDX_W{1'b1}};

    logic dest_is_pc;
    assign dest_is_pc = (dest_i == PC_IDX);

    always_comb begin
        fx_o      = '0;
        flag_ok_o = 1'b1;
        unique case (kind_e'(kind_i))
            KIND_REGWR: begin
                fx_o.reg_we = commit_i & ~dest_is_pc;
                fx_o.pc_we  = commit_i &  dest_is_pc;
            end
            KIND_STORE:   fx_o.mem_we = commit_i;
            KIND_PREFIX: begin
                fx_o.pre_we = commit_i;
                flag_ok_o   = 1'b0;
            end
            KIND_SYSCALL: fx_o.halt = commit_i;
            default:      fx_o = '0;
        endcase
    end
endmodule

// File: rtl/pred_exec_unit.sv
module pred_exec_unit
    import pred_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int REG_IDX_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 op_valid,
    input  logic [1:0]           cond_sel,
    input  logic [1:0]           op_kind,
    input  logic [REG_IDX_W-1:0] dest_idx,
    input  logic [DATA_W-1:0]    result,
    output logic                 commit,
    output logic                 reg_we,
    output logic                 pc_we,
    output logic                 mem_we,
    output logic                 pre_we,
    output logic                 halt,
    output logic                 zero_flag
);
    flag_state_t st_d, st_q;
    effect_t     fx;
    logic        set_req;
    logic        flag_ok;
    logic        res_is_zero;

    pred_cond_eval u_cond (
        .valid_i   (op_valid),
        .sfx_i     (cond_sel),
        .zero_i    (st_q.zero),
        .commit_o  (commit),
        .set_req_o (set_req)
    );

    pred_effect_gate #(.REG_IDX_W(REG_IDX_W)) u_gate (
        .commit_i  (commit),
        .kind_i    (op_kind),
        .dest_i    (dest_idx),
        .fx_o      (fx),
        .flag_ok_o (flag_ok)
    );

    assign res_is_zero = (result == '0);

    always_comb begin
        st_d = st_q;
        if (commit && set_req && flag_ok) begin
            st_d.zero = res_is_zero;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_we    = fx.reg_we;
    assign pc_we     = fx.pc_we;
    assign mem_we    = fx.mem_we;
    assign pre_we    = fx.pre_we;
    assign halt      = fx.halt;
    assign zero_flag = st_q.zero;
endmodule

// File: rtl/pred_exec_chk.sv
module pred_exec_chk #(
    parameter int DATA_W    = 16,
    parameter int REG_IDX_W = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 op_valid,
    input logic [1:0]           cond_sel,
    input logic [1:0]           op_kind,
    input logic [REG_IDX_W-1:0] dest_idx,
    input logic [DATA_W-1:0]    result,
    input logic                 commit,
    input logic                 reg_we,
    input logic                 pc_we,
    input logic                 mem_we,
    input logic                 pre_we,
    input logic                 halt,
    input logic                 zero_flag
);
    localparam logic [REG_IDX_W-1:0] PC_IDX = {REG_IDX_W{1'b1}};

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |-> !commit && !reg_we && !pc_we && !mem_we && !pre_we && !halt);

    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> zero_flag == $past(zero_flag));

    assert_always_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && cond_sel == 2'b00 |-> commit);

    assert_set_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && cond_sel == 2'b01 && op_kind != 2'b10 |=> zero_flag == ($past(result) == '0));

    assert_ifz_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && cond_sel == 2'b10 |-> commit == zero_flag);

    assert_ifnz_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && cond_sel == 2'b11 |-> commit == !zero_flag);

    assert_cond_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && cond_sel[1] |=> zero_flag == $past(zero_flag));

    assert_prefix_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_kind == 2'b10 |=> zero_flag == $past(zero_flag));

    assert_halt_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> commit && op_kind == 2'b11);

    assert_pc_dest_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we |-> commit && op_kind == 2'b00 && dest_idx == PC_IDX);

    assert_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_we, pc_we, mem_we, pre_we, halt}));

    assert_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we || pc_we || mem_we || pre_we || halt) |-> commit);
endmodule

bind pred_exec_unit pred_exec_chk #(.DATA_W(DATA_W), .REG_IDX_W(REG_IDX_W)) i_chk (.*);

// File: tb/test_pred_exec_unit.sv
module test_pred_exec_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 15;

    typedef struct packed {
        logic [1:0]  cond;
        logic [1:0]  kind;
        logic [3:0]  dest;
        logic [15:0] res;
        logic        exp_commit;
        logic [4:0]  exp_fx;   // {reg_we, pc_we, mem_we, pre_we, halt}
        logic        exp_zero; // flag after the edge
    } vec_t;

    // zero starts at 0 after reset; each row leaves the flag for the next
    localparam vec_t VECS [NVEC] = '{
        '{2'b00, 2'b00, 4'd3,  16'h0000, 1'b1, 5'b10000, 1'b0}, // R2
        '{2'b01, 2'b00, 4'd3,  16'h0000, 1'b1, 5'b10000, 1'b1}, // R3
        '{2'b10, 2'b00, 4'd15, 16'h0042, 1'b1, 5'b01000, 1'b1}, // R4 R8 branch taken
        '{2'b11, 2'b00, 4'd15, 16'h0042, 1'b0, 5'b00000, 1'b1}, // R5 R8 branch not taken
        '{2'b11, 2'b01, 4'd0,  16'h0001, 1'b0, 5'b00000, 1'b1}, // R5 R9
        '{2'b10, 2'b01, 4'd0,  16'h0001, 1'b1, 5'b00100, 1'b1}, // R4 R9
        '{2'b01, 2'b10, 4'd0,  16'h0005, 1'b1, 5'b00010, 1'b1}, // R6
        '{2'b01, 2'b01, 4'd0,  16'h0007, 1'b1, 5'b00100, 1'b0}, // R3 R9
        '{2'b10, 2'b11, 4'd0,  16'h0000, 1'b0, 5'b00000, 1'b0}, // R7 suppressed
        '{2'b11, 2'b10, 4'd0,  16'h0000, 1'b1, 5'b00010, 1'b0}, // R6 R5
        '{2'b01, 2'b10, 4'd0,  16'h0000, 1'b1, 5'b00010, 1'b0}, // R6
        '{2'b11, 2'b11, 4'd0,  16'h0000, 1'b1, 5'b00001, 1'b0}, // R7
        '{2'b01, 2'b00, 4'd15, 16'h0000, 1'b1, 5'b01000, 1'b1}, // R3 R8
        '{2'b00, 2'b00, 4'd14, 16'h0009, 1'b1, 5'b10000, 1'b1}, // R2 R8
        '{2'b01, 2'b11, 4'd0,  16'h8000, 1'b1, 5'b00001, 1'b0}  // R3 R7
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  cond_sel = '0;
    logic [1:0]  op_kind = '0;
    logic [3:0]  dest_idx = '0;
    logic [15:0] result = '0;
    logic        commit, reg_we, pc_we, mem_we, pre_we, halt, zero_flag;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pred_exec_unit i_pred_exec_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .cond_sel(cond_sel),
        .op_kind(op_kind), .dest_idx(dest_idx), .result(result),
        .commit(commit), .reg_we(reg_we), .pc_we(pc_we), .mem_we(mem_we),
        .pre_we(pre_we), .halt(halt), .zero_flag(zero_flag)
    );

    task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [4:0] fx_now();
        return {reg_we, pc_we, mem_we, pre_we, halt};
    endfunction

    task automatic drive(input logic v, input logic [1:0] c, input logic [1:0] k,
                         input logic [3:0] d, input logic [15:0] r);
        @(negedge clk);
        op_valid = v; cond_sel = c; op_kind = k; dest_idx = d; result = r;
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", "zero after reset", {7'd0, zero_flag}, 8'd0);
        check("R1", "strobes in reset idle", {2'd0, commit, fx_now()}, 8'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            drive(1'b1, VECS[i].cond, VECS[i].kind, VECS[i].dest, VECS[i].res);
            check("R2-R9 row", $sformatf("commit row %0d", i), {7'd0, commit}, {7'd0, VECS[i].exp_commit});
            check("R8 R9 row", $sformatf("strobes row %0d", i), {3'd0, fx_now()}, {3'd0, VECS[i].exp_fx});
            @(posedge clk); #1;
            check("R3 R6 row", $sformatf("zero row %0d", i), {7'd0, zero_flag}, {7'd0, VECS[i].exp_zero});
        end

        // R1: idle with set suffix and nonzero result must not touch a set flag
        drive(1'b1, 2'b01, 2'b00, 4'd1, 16'h0000);
        @(posedge clk); #1;
        check("R3", "flag set by zero result", {7'd0, zero_flag}, 8'd1);
        drive(1'b0, 2'b01, 2'b00, 4'd15, 16'h1234);
        check("R1", "idle strobes", {2'd0, commit, fx_now()}, 8'd0);
        @(posedge clk); #1;
        check("R1", "idle keeps flag", {7'd0, zero_flag}, 8'd1);

        // R4/R8: taken branch on flag=1, then same op with NE suppressed
        drive(1'b1, 2'b10, 2'b00, 4'd15, 16'h0000);
        check("R8", "ifz branch pc_we", {7'd0, pc_we}, 8'd1);
        drive(1'b1, 2'b11, 2'b00, 4'd15, 16'h0000);
        check("R8", "ifnz branch suppressed", {3'd0, fx_now()}, 8'd0);
        @(posedge clk); #1;
        check("R5", "suppressed keeps flag", {7'd0, zero_flag}, 8'd1);

        // R1: mid-run reset clears flag
        @(negedge clk);
        op_valid = 1'b0;
        rst_n = 1'b0;
        #1;
        check("R1", "async reset clears flag", {7'd0, zero_flag}, 8'd0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule